// File: doc/BRIEF.md
# GPIO Pin Event Flag Controller

This block watches a port of input pins and records, per pin, a configured event: a rising edge, a falling edge, either edge, or a held logic level. Each pin has a control word. The control word holds the event code, a function-select (mux) field and eight pad-setting bits. The pad bits are stored and read back only. A detected event sets a sticky flag bit whose index equals the pin number. The event code also decides what the flag drives. It either feeds a single CPU interrupt line, or it raises that pin's bit of a DMA request vector.

Software reaches the block over a simple word-addressed register bus. It reads and writes the per-pin control words. It reads the flag word and clears flags by writing ones to it. A DMA engine clears the flag of a DMA-configured pin by pulsing that pin's completion input. Pin inputs are asynchronous, so each pin passes through a two-flop synchronizer before edge detection. Configuration survives while the port is switched off.

Top module: `gpio_evt_flag_ctrl`

## Requirements
- R1: During and after synchronous reset, all flags, `irq_o`, `dma_req_o` and `bus_rdata` are zero, and every control word reads back as zero.
- R2: Reads have one cycle of latency. Word address p (p < NUM_PINS) is pin p's control word: event code in bits [19:16], mux field in bits [10:8], pad bits in [7:0], and a read-only copy of the pin's flag in bit 24. All other bits read zero. Address NUM_PINS is the flag word. Other addresses read zero.
- R3: Code 1001 raises the flag on a rising edge. An input change applied before clock edge k first shows in the flag, and in `irq_o`, after edge k+2, because of two synchronizer stages plus the flag register.
- R4: Code 1010 detects falling edges and code 1011 detects both edges, with the same latency as R3.
- R5: Code 1000 flags while the synchronized pin is 0 and code 1100 flags while it is 1. A write-one clear while the level still holds leaves the flag set. Once the level is gone, the clear takes effect.
- R6: Writing the flag word clears each flag whose written bit is 1 and leaves every other flag unchanged. Without a clear, a flag stays set.
- R7: If a clear (write-one or DMA completion) and a new detection fall on the same cycle, the flag remains set.
- R8: Codes 0001, 0010 and 0011 detect rising, falling and either edge as DMA sources. Their flags appear on the matching `dma_req_o` bit and not on `irq_o`. A `dma_done_i` pulse clears the flag of a DMA-configured pin and has no effect on any other pin.
- R9: `irq_o` is 1 exactly when some flag is set on a pin whose current code is 1000 to 1100. It updates on the same edge as the flags.
- R10: Code 0000 and every code outside the listed ones never set a flag.
- R11: Mux field value 000 (analog/off) disables event detection on that pin.
- R12: While `port_en` is 0, no new flags are set. Control words keep their values and remain readable and writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable; 0 halts detection, keeps configuration |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| dma_done_i | input | NUM_PINS | Per-pin DMA completion pulse |
| irq_o | output | 1 | Registered CPU interrupt |
| dma_req_o | output | NUM_PINS | Registered per-pin DMA requests |

## Verification
The bench builds the block with its defaults: 32 pins and a 32-bit data word, so the address width is 6. All 32 flag bits, the flag word and the flag mirror at bit 24 are therefore exercised at full width. With 32 pins the flag word has no unused high bits, so a clear mask that spills over the pin range cannot occur. The top pin index (31) and the flag-word address (32) sit right next to each other, and the bench exercises that boundary in address decoding.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int EVT_W    = 4;
  localparam int MUX_W    = 3;
  localparam int PAD_W    = 8;
  localparam int EVT_LSB  = 16;
  localparam int MUX_LSB  = 8;
  localparam int PAD_LSB  = 0;
  localparam int FLAG_BIT = 24;

  typedef struct packed {
    logic [EVT_W-1:0] evt;
    logic [MUX_W-1:0] mux;
    logic [PAD_W-1:0] pad;
  } pin_cfg_t;

  function automatic logic code_is_dma(input logic [EVT_W-1:0] c);
    return (c == 4'd1) || (c == 4'd2) || (c == 4'd3);
  endfunction

  function automatic logic code_is_irq(input logic [EVT_W-1:0] c);
    return (c >= 4'd8) && (c <= 4'd12);
  endfunction

  function automatic logic evt_match(input logic [EVT_W-1:0] c,
                                     input logic cur, input logic prv);
    case (c)
      4'd1, 4'd9:  return cur & ~prv;
      4'd2, 4'd10: return ~cur & prv;
      4'd3, 4'd11: return cur ^ prv;
      4'd8:        return ~cur;
      4'd12:       return cur;
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [W-1:0] stg1_q, stg2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1_q <= '0;
      stg2_q <= '0;
      prev_q <= '0;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
      prev_q <= stg2_q;
    end
  end

  assign q_o      = stg2_q;
  assign q_prev_o = prev_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
(
  input  logic [EVT_W-1:0] code_i,
  input  logic             en_i,
  input  logic             cur_i,
  input  logic             prev_i,
  output logic             hit_o,
  output logic             dma_sel_o,
  output logic             irq_sel_o
);
  always_comb begin
    dma_sel_o = code_is_dma(code_i);
    irq_sel_o = code_is_irq(code_i);
    hit_o     = en_i & evt_match(code_i, cur_i, prev_i);
  end
endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] w1c_i,
  input  logic [W-1:0] dma_done_i,
  input  logic [W-1:0] dma_sel_i,
  input  logic [W-1:0] irq_sel_i,
  output logic [W-1:0] flag_o,
  output logic         irq_o,
  output logic [W-1:0] dma_req_o
);
  logic [W-1:0] flag_q, flag_d, clr;
  logic         irq_q;
  logic [W-1:0] dma_q;

  always_comb begin
    clr    = w1c_i | (dma_done_i & dma_sel_i);
    flag_d = set_i | (flag_q & ~clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
      dma_q  <= '0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= |(flag_d & irq_sel_i);
      dma_q  <= flag_d & dma_sel_i;
    end
  end

  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign dma_req_o = dma_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_q[i]); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (w1c_i[i] && !set_i[i]) |=> !flag_q[i]); // R6
    AST_DMA_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (dma_done_i[i] && dma_sel_i[i] && !set_i[i]) |=> !flag_q[i]); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !w1c_i[i] && !(dma_done_i[i] && dma_sel_i[i])) |=> flag_q[i]); // R6
    AST_DMA_REQ_FLAG: assert property (@(posedge clk) disable iff (rst)
      dma_q[i] |-> flag_q[i]); // R8
  end
endmodule

// File: rtl/gpio_evt_flag_ctrl.sv
module gpio_evt_flag_ctrl
  import gpio_evt_pkg::*;
#(
  parameter  int NUM_PINS = 32,
  parameter  int DATA_W   = 32,
  localparam int ADDR_W   = $clog2(NUM_PINS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                port_en,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] dma_done_i,
  output logic                irq_o,
  output logic [NUM_PINS-1:0] dma_req_o
);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NUM_PINS);

  pin_cfg_t            cfg_q [NUM_PINS];
  logic [NUM_PINS-1:0] pin_s, pin_p, hit, dma_sel, irq_sel, flags, w1c;
  logic [DATA_W-1:0]   rd_word, rdata_q;

  gpio_sync #(.W(NUM_PINS)) i_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_s), .q_prev_o(pin_p)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_evt_detect i_det (
      .code_i   (cfg_q[i].evt),
      .en_i     (port_en && (cfg_q[i].mux != '0)),
      .cur_i    (pin_s[i]),
      .prev_i   (pin_p[i]),
      .hit_o    (hit[i]),
      .dma_sel_o(dma_sel[i]),
      .irq_sel_o(irq_sel[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[i] <= '0;
      end else if (bus_we && (bus_addr == ADDR_W'(i))) begin
        cfg_q[i].evt <= bus_wdata[EVT_LSB +: EVT_W];
        cfg_q[i].mux <= bus_wdata[MUX_LSB +: MUX_W];
        cfg_q[i].pad <= bus_wdata[PAD_LSB +: PAD_W];
      end
    end

    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (rst)
      (!port_en || cfg_q[i].mux == '0) && !flags[i] && !w1c[i] |=> !flags[i]); // R11
  end

  assign w1c = (bus_we && bus_addr == FLAG_ADDR) ? bus_wdata[NUM_PINS-1:0] : '0;

  gpio_flag_bank #(.W(NUM_PINS)) i_flags (
    .clk(clk), .rst(rst), .set_i(hit), .w1c_i(w1c), .dma_done_i(dma_done_i),
    .dma_sel_i(dma_sel), .irq_sel_i(irq_sel), .flag_o(flags),
    .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  always_comb begin
    rd_word = '0;
    if (bus_addr == FLAG_ADDR) begin
      rd_word[NUM_PINS-1:0] = flags;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (bus_addr == ADDR_W'(i)) begin
          rd_word[EVT_LSB +: EVT_W] = cfg_q[i].evt;
          rd_word[MUX_LSB +: MUX_W] = cfg_q[i].mux;
          rd_word[PAD_LSB +: PAD_W] = cfg_q[i].pad;
          rd_word[FLAG_BIT]         = flags[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_word;
  end
  assign bus_rdata = rdata_q;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flags != '0)); // R9
  AST_RDATA_RESET: assert property (@(posedge clk)
    $past(rst) |-> (bus_rdata == '0)); // R1
endmodule

// File: tb/test_gpio_evt_flag_ctrl.sv
module test_gpio_evt_flag_ctrl;
  localparam int NP = 32;
  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0, rst = 1'b1, port_en = 1'b1, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = AW'(NP);
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pin = '0, dma_done = '0, dma_req;
  logic          irq;

  always #2 clk = ~clk;

  gpio_evt_flag_ctrl #(.NUM_PINS(NP), .DATA_W(DW)) i_gpio_evt_flag_ctrl (
    .clk(clk), .rst(rst), .port_en(port_en), .pin_i(pin), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_done_i(dma_done), .irq_o(irq), .dma_req_o(dma_req)
  );

  int    checks = 0, fails = 0;
  string tag = "R1";

  logic [NP-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_flag = '0, m_dma = '0;
  logic          m_irq = 1'b0;
  logic [DW-1:0] m_rdata = '0;
  logic [3:0]    m_evt [NP];
  logic [2:0]    m_mux [NP];
  logic [7:0]    m_pad [NP];

  function automatic logic f_hit(input logic [3:0] c, input logic cur, input logic prv);
    case (c)
      4'd1, 4'd9:  return cur && !prv;
      4'd2, 4'd10: return !cur && prv;
      4'd3, 4'd11: return cur != prv;
      4'd8:        return !cur;
      4'd12:       return cur;
      default:     return 1'b0;
    endcase
  endfunction

  function automatic logic f_dma(input logic [3:0] c);
    return c >= 4'd1 && c <= 4'd3;
  endfunction

  function automatic logic f_irq(input logic [3:0] c);
    return c >= 4'd8 && c <= 4'd12;
  endfunction

  function automatic logic [DW-1:0] f_read(input logic [AW-1:0] a);
    logic [DW-1:0] w = '0;
    if (a == AW'(NP)) w = m_flag;
    else if (a < AW'(NP)) begin
      w[19:16] = m_evt[a];
      w[10:8]  = m_mux[a];
      w[7:0]   = m_pad[a];
      w[24]    = m_flag[a];
    end
    return w;
  endfunction

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    logic [NP-1:0] fn;
    logic [NP-1:0] clr;
    logic [DW-1:0] rn;
    rn = f_read(bus_addr);
    fn = '0;
    for (int i = 0; i < NP; i++) begin
      logic h;
      h = port_en && (m_mux[i] != 3'd0) && f_hit(m_evt[i], m_s2[i], m_prev[i]);
      clr[i] = (bus_we && bus_addr == AW'(NP) && bus_wdata[i]) || (dma_done[i] && f_dma(m_evt[i]));
      fn[i] = h || (m_flag[i] && !clr[i]);
    end
    m_irq = 1'b0;
    for (int i = 0; i < NP; i++) begin
      if (fn[i] && f_irq(m_evt[i])) m_irq = 1'b1;
      m_dma[i] = fn[i] && f_dma(m_evt[i]);
    end
    m_flag  = fn;
    m_rdata = rn;
    if (bus_we && bus_addr < AW'(NP)) begin
      m_evt[bus_addr] = bus_wdata[19:16];
      m_mux[bus_addr] = bus_wdata[10:8];
      m_pad[bus_addr] = bus_wdata[7:0];
    end
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = pin;
    @(negedge clk);
    chk("rdata", bus_rdata, m_rdata);
    chk("irq", DW'(irq), DW'(m_irq));
    chk("dma_req", DW'(dma_req), DW'(m_dma));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0; bus_addr = AW'(NP); bus_wdata = '0;
  endtask

  task automatic cfg(input int p, input logic [3:0] e, input logic [2:0] m);
    wr(AW'(p), {12'h0, e, 5'h0, m, 8'h5A});
  endtask

  task automatic rd(input int a);
    bus_addr = AW'(a);
    step();
    step();
    bus_addr = AW'(NP);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      m_evt[i] = '0; m_mux[i] = '0; m_pad[i] = '0;
    end
    void'($urandom(32'h1234_ABCD));
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("rdata_in_reset", bus_rdata, '0);
    chk("irq_in_reset", DW'(irq), '0);
    rst = 1'b0;
    rd(0);
    rd(NP - 1);
    rd(NP);

    tag = "R2";
    wr(AW'(5), '1);
    rd(5);
    chk("cfg5_layout", bus_rdata, 32'h000F_07FF);
    wr(AW'(NP - 1), 32'h0003_0142);
    rd(NP - 1);
    rd(NP + 3);

    tag = "R3";
    cfg(0, 4'd9, 3'd1);
    pin[0] = 1'b1;
    step(); step();
    chk("no_flag_before_sync", DW'(irq), '0);
    step();
    chk("flag_after_two_sync", DW'(irq), 32'd1);
    idle(3);

    tag = "R6";
    wr(AW'(NP), 32'h0000_0000);
    wr(AW'(NP), 32'h0000_0001);
    idle(2);
    chk("cleared", DW'(irq), '0);

    tag = "R4";
    cfg(1, 4'd10, 3'd2);
    cfg(2, 4'd11, 3'd3);
    pin[1] = 1'b1; idle(4);
    pin[1] = 1'b0; pin[2] = 1'b1; idle(4);
    wr(AW'(NP), 32'h0000_0006);
    pin[2] = 1'b0; idle(4);
    wr(AW'(NP), '1);

    tag = "R5";
    cfg(3, 4'd12, 3'd1);
    pin[3] = 1'b1; idle(4);
    wr(AW'(NP), 32'h0000_0008);
    idle(2);
    chk("level_holds", DW'(irq), 32'd1);
    pin[3] = 1'b0; idle(3);
    wr(AW'(NP), 32'h0000_0008);
    idle(2);
    cfg(4, 4'd8, 3'd1);
    idle(3);
    wr(AW'(NP), 32'h0000_0010);
    cfg(4, 4'd0, 3'd1);
    wr(AW'(NP), 32'h0000_0010);

    tag = "R7";
    cfg(6, 4'd11, 3'd1);
    pin[6] = 1'b1; idle(4);
    pin[6] = 1'b0; step(); step();
    wr(AW'(NP), 32'h0000_0040);
    idle(2);
    chk("set_wins", DW'(irq), 32'd1);
    wr(AW'(NP), 32'h0000_0040);

    tag = "R8";
    cfg(7, 4'd1, 3'd1);
    pin[7] = 1'b1; idle(4);
    chk("dma_req7", DW'(dma_req), 32'h80);
    cfg(0, 4'd9, 3'd1);
    pin[0] = 1'b0; idle(3); pin[0] = 1'b1; idle(4);
    dma_done = 32'h0000_0001; step(); dma_done = '0;
    idle(2);
    chk("irq_pin_unaffected", DW'(irq), 32'd1);
    dma_done = 32'h0000_0080; step(); dma_done = '0;
    idle(2);
    chk("dma_cleared", DW'(dma_req), '0);
    cfg(8, 4'd2, 3'd1);
    pin[8] = 1'b1; idle(3); pin[8] = 1'b0; idle(4);
    cfg(9, 4'd3, 3'd1);
    pin[9] = 1'b1; idle(4);
    dma_done = 32'h0000_0300; step(); dma_done = '0;
    wr(AW'(NP), '1);

    tag = "R10";
    cfg(10, 4'd5, 3'd1);
    cfg(11, 4'd15, 3'd1);
    cfg(12, 4'd0, 3'd1);
    pin[12:10] = 3'b111; idle(4);
    pin[12:10] = 3'b000; idle(4);

    tag = "R11";
    cfg(13, 4'd9, 3'd0);
    cfg(14, 4'd12, 3'd0);
    pin[14:13] = 2'b11; idle(5);
    chk("mux_off_no_flag", bus_rdata, '0);

    tag = "R12";
    port_en = 1'b0;
    cfg(15, 4'd9, 3'd4);
    pin[15] = 1'b1; idle(5);
    rd(15);
    chk("cfg_kept_off", bus_rdata, 32'h0009_045A);
    port_en = 1'b1;
    pin[15] = 1'b0; idle(3); pin[15] = 1'b1; idle(4);
    wr(AW'(NP), '1);

    tag = "R9";
    for (int i = 0; i < NP; i++) cfg(i, 4'd0, 3'd1);
    pin = '0; idle(3);
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic [3:0] codes [11] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd5, 4'd14};
      sel = int'($urandom % 100);
      pin      = pin ^ ($urandom & $urandom & $urandom);
      dma_done = $urandom & $urandom & $urandom;
      port_en  = ($urandom % 16) != 0;
      if (sel < 12) begin
        bus_we = 1'b1; bus_addr = AW'($urandom % NP);
        bus_wdata = {12'h0, codes[$urandom % 11], 5'h0, 3'($urandom % 8), 8'($urandom)};
      end else if (sel < 22) begin
        bus_we = 1'b1; bus_addr = AW'(NP); bus_wdata = $urandom & $urandom;
      end else if (sel < 30) begin
        bus_addr = AW'($urandom % (NP + 4));
      end else begin
        bus_addr = AW'(NP);
      end
      step();
      bus_we = 1'b0; dma_done = '0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule